// File: doc/BRIEF.md
# Byte-Accessed 16-bit Up/Down Counter with Shared High-Byte Staging

This block is a 16-bit counter that an 8-bit CPU data bus reads and writes one byte at a time. It keeps one shared 8-bit staging register for high bytes. Every 16-bit value is therefore loaded or sampled as a whole word in a single clock cycle, even though the bus is only a byte wide. The counter steps up or down by one on each timer enable pulse that an external prescaler supplies. A 3-bit clock select gates those pulses, and a clear input resets the count.

Next to the counter sit three 16-bit compare registers. Software loads them through the same staging register. It reads them back directly, without going through staging. The counter drives level outputs for its maximum and zero values. An overflow flag records an upward wrap, and software clears the flag by writing a one to it. An interrupt request is raised while both the flag and its enable are set.

Software must write the high byte before the low byte, and must read the low byte before the high byte. A low-byte read of the counter placed between the two halves of another access overwrites the staging register and corrupts that access.

Top module: `split_word_counter`

## Requirements
- R1: Byte address map: 0 is the counter low byte, 1 is the counter high byte, 2+2k and 3+2k are the low and high bytes of compare register k (k = 0..2), 8 is the overflow flag (bit 0) and 9 is the interrupt enable (bit 0). A write to any high-byte address (1, 3, 5, 7) only loads the staging register and leaves the counter unchanged. A write to address 0 loads the counter with {staging, data} in one cycle.
- R2: A read of address 0 returns the counter's low byte and, at the same clock edge, copies the counter's high byte into staging. A read of address 1 returns staging, so the two reads form one snapshot even if the counter moves between them.
- R3: After reset, the counter, staging, compare registers, flag and enable are all zero. Reads of unmapped addresses return zero.
- R4: On each cycle where the timer enable is high and the clock select is non-zero, the counter moves by one: up when the direction input is 1, down when it is 0. Both directions wrap modulo 2^16.
- R5: While the clock select is zero, timer enable pulses do not change the counter, but CPU reads and writes of the counter still take effect.
- R6: The clear input sets the counter to zero whether or not a timer enable is present. A CPU write to address 0 in the same cycle takes priority over both clear and count.
- R7: top_o is high exactly when the counter equals 0xFFFF. bottom_o is high exactly when the counter equals 0x0000.
- R8: The overflow flag sets only when an up-count takes the counter from 0xFFFF to 0x0000. A down-count wrap, a clear or a CPU load does not set it. If a set and a clear of the flag happen in the same cycle, the set wins.
- R9: Writing 1 to bit 0 at address 8 clears the flag. Bit 0 at address 9 holds the interrupt enable and reads back. ovf_irq_o is high while the flag and the enable are both set.
- R10: A write to a compare low address loads that register with {staging, data}. One high-byte write can serve several following low-byte writes to different compare registers.
- R11: Reads of compare registers return their bytes directly and leave staging unchanged.
- R12: A read of address 0 between the high and low writes of a compare register replaces the pending high byte with the counter's high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | 4 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_en_i is high |
| tick_i | input | 1 | One-cycle timer enable from the prescaler |
| clk_sel_i | input | 3 | Clock select; zero stops counting |
| dir_up_i | input | 1 | 1 counts up, 0 counts down |
| clear_i | input | 1 | Synchronous counter clear |
| top_o | output | 1 | Counter equals 0xFFFF |
| bottom_o | output | 1 | Counter equals 0x0000 |
| ovf_irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a 16-bit word, three compare registers and a 3-bit clock select. With these values the flag and enable addresses land at 8 and 9. Because the counter can be preloaded to 0xFFFF through the bus, both wrap directions and the maximum and zero indications are reached within a few cycles rather than 65536 timer pulses. With three compare registers, the bench can reuse one staged high byte across two registers and still have a third register left to detect a corrupted staging byte.

// File: rtl/sac_pkg.sv
`timescale 1ns/1ps
package sac_pkg;
  parameter int unsigned SAC_BYTE_W = 8;

  // Source of the next counter value, in priority order
  typedef enum logic [1:0] {
    NXT_HOLD  = 2'd0,
    NXT_STEP  = 2'd1,
    NXT_CLEAR = 2'd2,
    NXT_LOAD  = 2'd3
  } nxt_src_e;
endpackage

// File: rtl/sac_stage_reg.sv
`timescale 1ns/1ps
module sac_stage_reg #(
  parameter int unsigned BYTE_W = sac_pkg::SAC_BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              snap_i,
  input  logic [BYTE_W-1:0] snap_val_i,
  output logic [BYTE_W-1:0] stage_o
);
  logic [BYTE_W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stage_q <= '0;
    else if (hi_wr_i) stage_q <= wdata_i;
    else if (snap_i)  stage_q <= snap_val_i;
  end

  assign stage_o = stage_q;

  AST_STAGE_SNAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_i && !hi_wr_i) |=> stage_o == $past(snap_val_i)); // R2
  AST_STAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snap_i && !hi_wr_i) |=> $stable(stage_o)); // R11
endmodule

// File: rtl/sac_count_core.sv
`timescale 1ns/1ps
module sac_count_core #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CS_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CS_W-1:0]   clk_sel_i,
  input  logic              dir_up_i,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_val_i,
  output logic [WORD_W-1:0] count_o,
  output logic              top_o,
  output logic              bottom_o,
  output logic              wrap_up_o
);
  import sac_pkg::*;

  localparam logic [WORD_W-1:0] MAX_VAL = {WORD_W{1'b1}};
  localparam logic [WORD_W-1:0] ONE     = WORD_W'(1);

  logic [WORD_W-1:0] cnt_q, cnt_d;
  logic              step_en;
  nxt_src_e          src;

  assign step_en = tick_i && (clk_sel_i != '0);

  always_comb begin
    if (load_i)       src = NXT_LOAD;
    else if (clear_i) src = NXT_CLEAR;
    else if (step_en) src = NXT_STEP;
    else              src = NXT_HOLD;
  end

  always_comb begin
    unique case (src)
      NXT_LOAD:  cnt_d = load_val_i;
      NXT_CLEAR: cnt_d = '0;
      NXT_STEP:  cnt_d = dir_up_i ? cnt_q + ONE : cnt_q - ONE;
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o   = cnt_q;
  assign top_o     = (cnt_q == MAX_VAL);
  assign bottom_o  = (cnt_q == '0);
  assign wrap_up_o = (src == NXT_STEP) && dir_up_i && top_o;

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i)); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !load_i) |=> bottom_o); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clear_i && clk_sel_i == '0) |=> $stable(count_o)); // R5
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clear_i && tick_i && clk_sel_i != '0 && dir_up_i)
      |=> count_o == $past(count_o) + ONE); // R4
  AST_WRAP_TO_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_up_o |=> bottom_o); // R8
endmodule

// File: rtl/sac_cmp_bank.sv
`timescale 1ns/1ps
module sac_cmp_bank #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned NUM_CMP = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CMP-1:0]             lo_wr_i,
  input  logic [WORD_W-1:0]              word_i,
  output logic [NUM_CMP-1:0][WORD_W-1:0] cmp_o
);
  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    logic [WORD_W-1:0] val_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         val_q <= '0;
      else if (lo_wr_i[k]) val_q <= word_i;
    end

    assign cmp_o[k] = val_q;

    AST_CMP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lo_wr_i[k] |=> cmp_o[k] == $past(word_i)); // R10
    AST_CMP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lo_wr_i[k] |=> $stable(cmp_o[k])); // R10
  end
endmodule

// File: rtl/sac_ovf_csr.sv
`timescale 1ns/1ps
module sac_ovf_csr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic flag_clr_i,
  input  logic en_wr_i,
  input  logic en_val_i,
  output logic flag_o,
  output logic en_o,
  output logic irq_o
);
  logic flag_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      // set beats software clear
      if (wrap_i)          flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      if (en_wr_i)         en_q   <= en_val_i;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign irq_o  = flag_q && en_q;

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> flag_o); // R8
  AST_FLAG_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !wrap_i) |=> !flag_o); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_clr_i && flag_o) |=> flag_o); // R8
endmodule

// File: rtl/split_word_counter.sv
`timescale 1ns/1ps
module split_word_counter #(
  parameter int unsigned BYTE_W  = sac_pkg::SAC_BYTE_W,
  parameter int unsigned NUM_CMP = 3,
  parameter int unsigned CS_W    = 3,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic [CS_W-1:0]   clk_sel_i,
  input  logic              dir_up_i,
  input  logic              clear_i,
  output logic              top_o,
  output logic              bottom_o,
  output logic              ovf_irq_o
);
  localparam int unsigned WORD_W    = 2 * BYTE_W;
  localparam int unsigned FLAG_ADDR = 2 + 2 * NUM_CMP;
  localparam int unsigned EN_ADDR   = FLAG_ADDR + 1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = '0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FLAG   = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] A_EN     = ADDR_W'(EN_ADDR);

  logic                           hi_wr, cnt_lo_wr, cnt_lo_rd;
  logic                           flag_clr, en_wr;
  logic [NUM_CMP-1:0]             cmp_lo_wr;
  logic [BYTE_W-1:0]              stage;
  logic [WORD_W-1:0]              count, staged_word;
  logic [NUM_CMP-1:0][WORD_W-1:0] cmp;
  logic                           wrap_up, flag, irq_en;

  // odd addresses below the flag are high-byte slots
  assign hi_wr     = wr_en_i && addr_i[0] && (addr_i < A_FLAG);
  assign cnt_lo_wr = wr_en_i && (addr_i == A_CNT_LO);
  assign cnt_lo_rd = rd_en_i && (addr_i == A_CNT_LO);
  assign flag_clr  = wr_en_i && (addr_i == A_FLAG) && wdata_i[0];
  assign en_wr     = wr_en_i && (addr_i == A_EN);

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_dec
    assign cmp_lo_wr[k] = wr_en_i && (addr_i == ADDR_W'(2 + 2 * k));
  end

  assign staged_word = {stage, wdata_i};

  sac_stage_reg #(.BYTE_W(BYTE_W)) u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hi_wr_i    (hi_wr),
    .wdata_i    (wdata_i),
    .snap_i     (cnt_lo_rd),
    .snap_val_i (count[WORD_W-1:BYTE_W]),
    .stage_o    (stage)
  );

  sac_count_core #(.WORD_W(WORD_W), .CS_W(CS_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .clk_sel_i  (clk_sel_i),
    .dir_up_i   (dir_up_i),
    .clear_i    (clear_i),
    .load_i     (cnt_lo_wr),
    .load_val_i (staged_word),
    .count_o    (count),
    .top_o      (top_o),
    .bottom_o   (bottom_o),
    .wrap_up_o  (wrap_up)
  );

  sac_cmp_bank #(.WORD_W(WORD_W), .NUM_CMP(NUM_CMP)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_wr_i (cmp_lo_wr),
    .word_i  (staged_word),
    .cmp_o   (cmp)
  );

  sac_ovf_csr u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wrap_i     (wrap_up),
    .flag_clr_i (flag_clr),
    .en_wr_i    (en_wr),
    .en_val_i   (wdata_i[0]),
    .flag_o     (flag),
    .en_o       (irq_en),
    .irq_o      (ovf_irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (addr_i == A_CNT_LO)      rdata_o = count[BYTE_W-1:0];
      else if (addr_i == A_CNT_HI) rdata_o = stage;
      else if (addr_i == A_FLAG)   rdata_o = BYTE_W'(flag);
      else if (addr_i == A_EN)     rdata_o = BYTE_W'(irq_en);
      for (int k = 0; k < NUM_CMP; k++) begin
        if (addr_i == ADDR_W'(2 + 2 * k)) rdata_o = cmp[k][BYTE_W-1:0];
        if (addr_i == ADDR_W'(3 + 2 * k)) rdata_o = cmp[k][WORD_W-1:BYTE_W];
      end
    end
  end

  AST_HI_WRITE_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wr && !clear_i && !tick_i) |=> $stable(count)); // R1
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en && !en_wr) |=> !ovf_irq_o); // R9
endmodule

// File: tb/tb_split_word_counter.sv
`timescale 1ns/1ps
module tb_split_word_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tick = 1'b0, dir_up = 1'b1, clear = 1'b0;
  logic [2:0] clk_sel = '0;
  logic       top, bottom, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  split_word_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick),
    .clk_sel_i(clk_sel), .dir_up_i(dir_up), .clear_i(clear),
    .top_o(top), .bottom_o(bottom), .ovf_irq_o(irq)
  );

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    #1;
    if (rd_en) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s addr=%0d actual=%02h expected=%02h", t, addr, rdata, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d,
                    input logic clr = 1'b0, input logic tk = 1'b0);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; clear = clr; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; clear = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic clr);
    @(negedge clk);
    tick = 1'b1; clear = clr;
    @(negedge clk);
    tick = 1'b0; clear = 1'b0;
  endtask

  task automatic pin(input logic act, input logic e, input string t);
    @(negedge clk);
    #1;
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s pin actual=%0b expected=%0b", t, act, e);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state
    rd(4'd0, 8'h00, "R3 cnt lo");
    rd(4'd1, 8'h00, "R3 stage");
    rd(4'd3, 8'h00, "R3 cmp0 hi");
    rd(4'd8, 8'h00, "R3 flag");
    rd(4'd12, 8'h00, "R3 unmapped");
    pin(bottom, 1'b1, "R7 bottom at reset");
    pin(irq, 1'b0, "R3 irq");

    // R1 split write, R2 split read
    wr(4'd1, 8'h12); wr(4'd0, 8'hAB);
    rd(4'd0, 8'hAB, "R1 lo");
    rd(4'd1, 8'h12, "R2 hi");
    wr(4'd1, 8'h99);
    rd(4'd0, 8'hAB, "R1 hi write alone");
    rd(4'd1, 8'h12, "R1 counter hi unchanged");

    // R5 stopped clock select
    clk_sel = 3'd0;
    pulse(1'b0); pulse(1'b0);
    rd(4'd0, 8'hAB, "R5 hold");
    wr(4'd1, 8'h12); wr(4'd0, 8'hFF);
    rd(4'd0, 8'hFF, "R5 cpu write while stopped");

    // R2 snapshot across a carry
    clk_sel = 3'd1; dir_up = 1'b1;
    rd(4'd0, 8'hFF, "R2 snap lo");
    pulse(1'b0);
    rd(4'd1, 8'h12, "R2 snap hi old");
    rd(4'd0, 8'h00, "R4 up carry lo");
    rd(4'd1, 8'h13, "R4 up carry hi");

    // R4 up/down
    pulse(1'b0); pulse(1'b0);
    rd(4'd0, 8'h02, "R4 up two");
    dir_up = 1'b0;
    pulse(1'b0);
    rd(4'd0, 8'h01, "R4 down");

    // R6 clear, priority
    clk_sel = 3'd0;
    pulse(1'b1);
    pin(bottom, 1'b1, "R6 clear without count enable");
    clk_sel = 3'd2;
    wr(4'd1, 8'h40); wr(4'd0, 8'h05, 1'b1, 1'b1);
    rd(4'd0, 8'h05, "R6 write beats clear lo");
    rd(4'd1, 8'h40, "R6 write beats clear hi");
    pulse(1'b1);
    rd(4'd0, 8'h00, "R6 clear beats tick");
    rd(4'd1, 8'h00, "R6 clear hi");

    // R7, R8, R9 overflow
    dir_up = 1'b1;
    wr(4'd1, 8'hFF); wr(4'd0, 8'hFF);
    pin(top, 1'b1, "R7 top");
    pin(bottom, 1'b0, "R7 not bottom");
    rd(4'd8, 8'h00, "R8 no flag from load");
    pulse(1'b0);
    pin(bottom, 1'b1, "R7 bottom after wrap");
    rd(4'd8, 8'h01, "R8 flag set");
    pin(irq, 1'b0, "R9 irq masked");
    wr(4'd9, 8'h01);
    rd(4'd9, 8'h01, "R9 enable readback");
    pin(irq, 1'b1, "R9 irq raised");
    wr(4'd8, 8'h00);
    rd(4'd8, 8'h01, "R9 write zero keeps flag");
    wr(4'd8, 8'h01);
    rd(4'd8, 8'h00, "R9 w1c");
    pin(irq, 1'b0, "R9 irq dropped");
    dir_up = 1'b0;
    pulse(1'b0);
    rd(4'd8, 8'h00, "R8 down wrap no flag");
    rd(4'd0, 8'hFF, "R4 down wrap lo");
    rd(4'd1, 8'hFF, "R4 down wrap hi");
    // R8 set wins over same-cycle clear
    dir_up = 1'b1;
    wr(4'd8, 8'h01, 1'b0, 1'b1);
    rd(4'd8, 8'h01, "R8 set beats clear");
    wr(4'd8, 8'h01);

    // R10 staging reuse, R11 direct compare read
    clk_sel = 3'd0;
    wr(4'd3, 8'h3C); wr(4'd2, 8'h11); wr(4'd4, 8'h22);
    rd(4'd2, 8'h11, "R10 cmp0 lo");
    rd(4'd3, 8'h3C, "R10 cmp0 hi");
    rd(4'd5, 8'h3C, "R10 cmp1 reused hi");
    rd(4'd4, 8'h22, "R10 cmp1 lo");
    wr(4'd7, 8'h77);
    rd(4'd3, 8'h3C, "R11 cmp0 hi direct");
    rd(4'd2, 8'h11, "R11 cmp0 lo direct");
    wr(4'd6, 8'h33);
    rd(4'd7, 8'h77, "R11 stage kept across cmp reads");

    // R12 interleaved counter read corrupts pending write
    wr(4'd1, 8'h9A); wr(4'd0, 8'h00);
    wr(4'd5, 8'h55);
    rd(4'd0, 8'h00, "R12 interleaved lo read");
    wr(4'd4, 8'h66);
    rd(4'd5, 8'h9A, "R12 corrupted cmp1 hi");
    rd(4'd4, 8'h66, "R12 cmp1 lo");

    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule